// File: doc/BRIEF.md
# Strobe-Handshake Bus Cycle Sequencer

This block is a bus master for peripherals that end each transfer with an acknowledge. It takes one read or write request at a time from an internal requester and runs it on the external bus as a fixed series of eight states, S0 to S7. The bus signals are an active-low address strobe, an active-low data strobe, a read/write line (high for read), the address, and a data bus with an output enable. Each state lasts a programmable number of core clocks, set by `CYC_CLKS` (1 to 15). The state machine moves forward only when an internal clock-enable pulse fires.

During S4 the block waits for an active-low acknowledge from the peripheral. The acknowledge passes through a synchronizer and is sampled one core clock before the last clock of S4. If it has not been seen, a whole bus state of waiting is added, and this repeats until the acknowledge arrives. For a read, the block captures the data bus on the edge that enters S7. When the cycle has ended, it returns the captured data together with a one-clock completion pulse.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset and while idle: `as_n`=1, `ds_n`=1, `rw`=1, `bus_oe`=0, `req_ready`=1, `done`=0.
- R2: A request is taken only when `req_valid` is high and the block is idle. `req_ready` is 0 from the clock after acceptance until completion. A `req_valid` raised while busy does not change the address on the bus and does not start a second cycle.
- R3: Each of S0..S7 lasts `CYC_CLKS` clocks, and the state changes only on the enable pulse. `bus_addr` shows the request address from the entry into S1 until completion.
- R4: For a write, `as_n` falls and `rw` falls on the entry into S2. `rw` stays 0 through S7 and returns to 1 on the edge that ends S7.
- R5: `bus_oe` is 1 exactly from the entry into S3 until the end of S7 of a write. It is never 1 during a read.
- R6: `ds_n` falls on the entry into S4. Both strobes rise on the entry into S7. `ds_n` is never 0 while `as_n` is 1.
- R7: `dtack_n` (active low) passes through a two-flop synchronizer. It is sampled on the clock before the final clock of S4 or of a wait state. If it has not been seen, one wait state of `CYC_CLKS` clocks is added, and wait states repeat until it is seen.
- R8: For a read, `bus_din` is captured on the edge that enters S7 and appears on `rd_data` in the cycle where `done` is 1.
- R9: `done` is a one-clock pulse. It appears (8 + W)·`CYC_CLKS` clocks after the accepting edge, where W is the number of wait states.
- R10: For a read, `rw` stays 1 for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External data, outgoing |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | External data, incoming |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| dtack_n | input | 1 | Transfer acknowledge, active low |

## Verification
The assertions check the strobe relations on every cycle:
- the data strobe is never active without the address strobe;
- the output enable is never on with the line in read;
- the bus is quiet while idle;
- `done` lasts a single clock;
- the state holds between enable pulses;
- a missing acknowledge leads into a wait state.

Only the bench's scenarios can show the exact clock on which each edge occurs, the number of wait states for a given arrival time of the acknowledge (including the boundary where one clock decides between zero and one wait), the captured read value, and that a request made while busy is ignored.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_S0   = 4'd1,
      ST_S1   = 4'd2,
      ST_S2   = 4'd3,
      ST_S3   = 4'd4,
      ST_S4   = 4'd5,
      ST_S5   = 4'd6,
      ST_S6   = 4'd7,
      ST_S7   = 4'd8,
      ST_WAIT = 4'd9
   } bsq_state_e;

   typedef struct packed {
      logic as_n;
      logic ds_n;
      logic rw;
      logic oe;
   } bsq_pins_t;

   localparam bsq_pins_t BSQ_PINS_IDLE = '{as_n: 1'b1, ds_n: 1'b1, rw: 1'b1, oe: 1'b0};

   function automatic bsq_pins_t bsq_decode(input bsq_state_e st, input logic wr);
      bsq_pins_t p;
      p = BSQ_PINS_IDLE;
      unique case (st)
         ST_S2: begin
            p.as_n = 1'b0;
            p.rw   = ~wr;
         end
         ST_S3: begin
            p.as_n = 1'b0;
            p.rw   = ~wr;
            p.oe   = wr;
         end
         ST_S4, ST_WAIT, ST_S5, ST_S6: begin
            p.as_n = 1'b0;
            p.ds_n = 1'b0;
            p.rw   = ~wr;
            p.oe   = wr;
         end
         ST_S7: begin
            p.rw = ~wr;
            p.oe = wr;
         end
         default: p = BSQ_PINS_IDLE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/bsq_tick.sv
module bsq_tick #(
   parameter int CYC_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick,
   output logic pre_tick
);

   localparam int CNT_W = (CYC_CLKS < 2) ? 1 : $clog2(CYC_CLKS);

   generate
      if (CYC_CLKS == 1) begin : g_every
         assign tick     = run;
         assign pre_tick = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_CLKS - 1);
         localparam logic [CNT_W-1:0] PRE  = CNT_W'(CYC_CLKS - 2);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!run)           cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick     = run && (cnt_q == LAST);
         assign pre_tick = run && (cnt_q == PRE);

         // R3
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/bsq_sync.sv
module bsq_sync #(
   parameter int   STAGES   = 2,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
   import bsq_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int CYC_CLKS = 4,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pre_tick,
   input  logic              ack_sync,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_din,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output bsq_pins_t         pins
);

   bsq_state_e        state_q, state_d;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ack_seen;

   generate
      if (CYC_CLKS > 1) begin : g_early_sample
         logic ack_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ack_q <= 1'b0;
            else if (pre_tick) ack_q <= ack_sync;
         end
         assign ack_seen = ack_q;
      end else begin : g_direct_sample
         logic unused_pre;
         assign unused_pre = pre_tick;
         assign ack_seen   = ack_sync;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (state_q == ST_IDLE) begin
         if (req_valid) state_d = ST_S0;
      end else if (tick) begin
         unique case (state_q)
            ST_S0:          state_d = ST_S1;
            ST_S1:          state_d = ST_S2;
            ST_S2:          state_d = ST_S3;
            ST_S3:          state_d = ST_S4;
            ST_S4, ST_WAIT: state_d = ack_seen ? ST_S5 : ST_WAIT;
            ST_S5:          state_d = ST_S6;
            ST_S6:          state_d = ST_S7;
            ST_S7:          state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         wr_q     <= 1'b0;
         addr_q   <= '0;
         bus_dout <= '0;
         bus_addr <= '0;
         rd_data  <= '0;
         done     <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == ST_S7) && tick;
         if (state_q == ST_IDLE && req_valid) begin
            wr_q     <= req_write;
            addr_q   <= req_addr;
            bus_dout <= req_wdata;
         end
         if (state_q == ST_S0 && tick) bus_addr <= addr_q;
         if (state_q == ST_S6 && tick && !wr_q) rd_data <= bus_din;
      end
   end

   assign busy = (state_q != ST_IDLE);

   generate
      if (REG_OUT) begin : g_reg_pins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins <= BSQ_PINS_IDLE;
            else        pins <= bsq_decode(state_d, wr_q);
         end
      end else begin : g_comb_pins
         assign pins = bsq_decode(state_q, wr_q);
      end
   endgenerate

   // R3
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> (state_q == $past(state_q)));

   // R7
   wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (state_q == ST_S4 || state_q == ST_WAIT) && !ack_seen) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
   import bsq_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 8,
   parameter int CYC_CLKS    = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_din,
   output logic              as_n,
   output logic              ds_n,
   output logic              rw,
   input  logic              dtack_n
);

   initial begin
      cyc_range_chk: assert (CYC_CLKS >= 1 && CYC_CLKS <= 15)
         else $error("CYC_CLKS out of range");
      sync_depth_chk: assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES below two");
      width_chk: assert (ADDR_W >= 1 && DATA_W >= 1)
         else $error("bad bus width");
   end

   logic      busy, tick, pre_tick, ack_n_sync;
   bsq_pins_t pins;

   bsq_tick #(.CYC_CLKS(CYC_CLKS)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .tick     (tick),
      .pre_tick (pre_tick)
   );

   bsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (dtack_n),
      .dout  (ack_n_sync)
   );

   bsq_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CYC_CLKS (CYC_CLKS),
      .REG_OUT  (REG_OUT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pre_tick  (pre_tick),
      .ack_sync  (~ack_n_sync),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .bus_din   (bus_din),
      .busy      (busy),
      .done      (done),
      .rd_data   (rd_data),
      .bus_addr  (bus_addr),
      .bus_dout  (bus_dout),
      .pins      (pins)
   );

   assign req_ready = ~busy;
   assign as_n      = pins.as_n;
   assign ds_n      = pins.ds_n;
   assign rw        = pins.rw;
   assign bus_oe    = pins.oe;

   // R6
   ds_within_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ds_n |-> !as_n);

   // R5
   oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !rw);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (as_n && ds_n && rw && !bus_oe));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/sim_strobe_bus_master.sv
module sim_strobe_bus_master;

   localparam int AW  = 24;
   localparam int DW  = 8;
   localparam int CYC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dout;
   logic          bus_oe;
   logic [DW-1:0] bus_din = '0;
   logic          as_n, ds_n, rw;
   logic          dtack_n = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   strobe_bus_master #(.ADDR_W(AW), .DATA_W(DW), .CYC_CLKS(CYC)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rd_data(rd_data),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
      .as_n(as_n), .ds_n(ds_n), .rw(rw), .dtack_n(dtack_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      // R1
      check(as_n == 1'b1 && ds_n == 1'b1, "R1 strobes idle", {as_n, ds_n}, 3);
      check(rw == 1'b1 && bus_oe == 1'b0, "R1 rw/oe idle", {rw, bus_oe}, 2);
      check(req_ready == 1'b1 && done == 1'b0, "R1 ready/done", {req_ready, done}, 2);
   endtask

   // dt_cyc: cycle after the accepting edge in which dtack_n is pulled low
   task automatic run_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int dt_cyc, input bit poke);
      int w, exp_done, s7, done_c;
      int bad_as, bad_ds, bad_rw, bad_oe, bad_addr, bad_dout, ready_c0;
      logic [DW-1:0] got;
      bit exp_as, exp_ds, exp_rw, exp_oe;
      w        = (dt_cyc <= 16) ? 0 : (dt_cyc - 16 + 3) / 4;
      exp_done = 32 + 4 * w;
      s7       = 28 + 4 * w;
      done_c   = -1;
      bad_as = 0; bad_ds = 0; bad_rw = 0; bad_oe = 0; bad_addr = 0; bad_dout = 0;
      ready_c0 = 1; got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      bus_din = wr ? ~d : d;
      @(posedge clk);
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (c == 0) begin
            req_valid = 1'b0;
            ready_c0  = req_ready;
         end
         if (done) begin
            done_c = c;
            got    = rd_data;
            break;
         end
         exp_as = !(c >= 8 && c < s7);
         exp_ds = !(c >= 16 && c < s7);
         exp_rw = !(wr && c >= 8);
         exp_oe = wr && c >= 12;
         if (as_n !== exp_as) bad_as++;
         if (ds_n !== exp_ds) bad_ds++;
         if (rw !== exp_rw) bad_rw++;
         if (bus_oe !== exp_oe) bad_oe++;
         if (c >= 4 && bus_addr !== a) bad_addr++;
         if (wr && exp_oe && bus_dout !== d) bad_dout++;
         if (poke && c == 5) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a;
         end
         if (poke && c == 6) req_valid = 1'b0;
         if (c == dt_cyc) dtack_n = 1'b0;
      end
      dtack_n = 1'b1;
      // R2
      check(ready_c0 == 0, "R2 ready low while busy", ready_c0, 0);
      // R9 R7
      check(done_c == exp_done, "R9/R7 done cycle", done_c, exp_done);
      // R4 R6
      check(bad_as == 0, "R4/R6 as_n timing", bad_as, 0);
      // R6
      check(bad_ds == 0, "R6 ds_n timing", bad_ds, 0);
      // R4 R10
      check(bad_rw == 0, wr ? "R4 rw timing" : "R10 rw high on read", bad_rw, 0);
      // R5
      check(bad_oe == 0, "R5 bus_oe timing", bad_oe, 0);
      // R3
      check(bad_addr == 0, "R3 address held", bad_addr, 0);
      if (wr) check(bad_dout == 0, "R5 write data", bad_dout, 0);
      // R8
      else    check(got == d, "R8 read data", got, d);
      @(negedge clk);
      // R9
      check(done == 1'b0, "R9 done single pulse", done, 0);
      if (poke) begin
         int stray;
         stray = 0;
         for (int k = 0; k < 12; k++) begin
            if (!as_n || !req_ready) stray++;
            @(negedge clk);
         end
         // R2
         check(stray == 0, "R2 busy request ignored", stray, 0);
      end
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            test_reset();
            run_xfer(1'b1, 24'h12_3456, 8'hA5, 10, 1'b0); // write, no wait
            run_xfer(1'b0, 24'h00_0F0F, 8'h3C, 16, 1'b0); // read, last no-wait clock
            run_xfer(1'b1, 24'hFE_DCBA, 8'h5A, 17, 1'b0); // R7 one wait
            run_xfer(1'b0, 24'h80_0001, 8'hC3, 25, 1'b0); // R7 three waits
            run_xfer(1'b1, 24'h55_AA55, 8'h81, 0, 1'b1);  // R2 request while busy
            test_reset();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule